// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block carries out the hardware side of entering an interrupt or exception handler when the core runs in real-address mode. A one-cycle `start` pulse hands it a vector number and the current FLAGS, CS, IP, SS and SP. It then saves the return state as three 16-bit words on the stack through a write port. Each stack address is the segment times sixteen plus the offset. Next it fetches the handler's offset and segment from the vector table through a read port that answers with a valid strobe.

When the segment word arrives, the block raises `done` for one cycle. In that cycle it presents the handler's CS and IP, the adjusted SP and the FLAGS value the handler starts with. The frame has the same shape for every vector. A vector that would add a fault code in a protected-mode frame still gets only the three words here.

Top module: `rmode_int_entry`

## Requirements
- R1: The table offset word is read from linear address vector×4, and after it the segment word is read from vector×4+2. Each read request lasts exactly one cycle.
- R2: Three words are written to the stack, in this order: the low 16 bits of FLAGS, then CS, then the low 16 bits of IP. The offset is lowered by 2 before each write, so the writes land at SP-2, SP-4 and SP-6 within SS. A write and a read are never requested in the same cycle.
- R3: Stack offsets wrap modulo 65536 inside the stack segment. The SP presented at `done` equals (SP-6) mod 65536.
- R4: Exactly three writes happen between `start` and `done` for every vector, including the vectors 8, 10 to 14 and 17. No fault code is ever written.
- R5: `new_flags` equals the input FLAGS with bit 8 (trap), bit 9 (interrupt enable), bit 16 (resume) and bit 18 (alignment check) cleared. All other bits are unchanged.
- R6: `new_ip` is the 16-bit table offset zero-extended to 32 bits, and `new_cs` is the table segment word.
- R7: `done` is a one-cycle pulse in the cycle after the segment read returns. `busy` is high from the cycle after `start` until `done` rises.
- R8: A `start` that arrives while `busy` is high is ignored, and the entry in progress completes with its original operands.
- R9: After reset, `busy`, `done`, `wr_en` and `rd_req` are low.
- R10: A linear address is (segment×16 + offset) truncated to ADDR_W bits, which is 20 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an entry sequence (accepted when idle) |
| vector | input | VEC_W | Interrupt or exception number |
| flags_in | input | 32 | Current FLAGS |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 32 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack offset |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | ADDR_W | Stack write linear address |
| wr_data | output | 16 | Stack write word |
| rd_req | output | 1 | Table read request (one cycle) |
| rd_addr | output | ADDR_W | Table read linear address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Handler address valid (one cycle) |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 32 | Handler instruction pointer |
| new_sp | output | 16 | Stack offset after the pushes |
| new_flags | output | 32 | FLAGS for the handler |

## Verification
Two situations are hard to reach from the ports. The first is stack wrap: one push lands at the top of the segment, or segment plus offset overflows the 20-bit space. The second is a second `start` pulse in the middle of a sequence. Directed runs use SP values of 0 and 2 and the pair SS=FFFF/SP=FFF0. One run injects a conflicting start during the push phase. Random runs draw all operands from a seeded generator, and the chosen vectors include the ones that carry fault codes elsewhere.

// File: rtl/rmie_pkg.sv
package rmie_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned FLAGS_W = 32;
    localparam int unsigned IP_W    = 32;

    localparam int unsigned BIT_TRAP   = 8;
    localparam int unsigned BIT_INTEN  = 9;
    localparam int unsigned BIT_RESUME = 16;
    localparam int unsigned BIT_ALIGN  = 18;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP,
        ST_REQ_OFS, ST_WAIT_OFS, ST_REQ_SEG, ST_WAIT_SEG
    } seq_state_e;

    typedef enum logic [1:0] {SRC_FLAGS, SRC_CS, SRC_IP} push_src_e;

    typedef struct packed {
        logic      load;
        logic      push;
        push_src_e src;
        logic      rd_req;
        logic      rd_seg;
        logic      cap_ofs;
        logic      cap_seg;
    } ctl_t;

    function automatic logic [FLAGS_W-1:0] strip_ctrl(input logic [FLAGS_W-1:0] f);
        logic [FLAGS_W-1:0] r;
        r = f;
        r[BIT_TRAP]   = 1'b0;
        r[BIT_INTEN]  = 1'b0;
        r[BIT_RESUME] = 1'b0;
        r[BIT_ALIGN]  = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/rmie_ctrl.sv
module rmie_ctrl
    import rmie_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rd_valid,
    output ctl_t ctl,
    output logic busy,
    output logic done
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE:     if (start) state <= ST_PUSH_FL;
                ST_PUSH_FL:  state <= ST_PUSH_CS;
                ST_PUSH_CS:  state <= ST_PUSH_IP;
                ST_PUSH_IP:  state <= ST_REQ_OFS;
                ST_REQ_OFS:  state <= ST_WAIT_OFS;
                ST_WAIT_OFS: if (rd_valid) state <= ST_REQ_SEG;
                ST_REQ_SEG:  state <= ST_WAIT_SEG;
                ST_WAIT_SEG: if (rd_valid) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl         = '0;
        ctl.src     = SRC_FLAGS;
        ctl.load    = (state == ST_IDLE) && start;
        ctl.push    = (state == ST_PUSH_FL) || (state == ST_PUSH_CS) || (state == ST_PUSH_IP);
        if (state == ST_PUSH_CS) ctl.src = SRC_CS;
        if (state == ST_PUSH_IP) ctl.src = SRC_IP;
        ctl.rd_req  = (state == ST_REQ_OFS) || (state == ST_REQ_SEG);
        ctl.rd_seg  = (state == ST_REQ_SEG);
        ctl.cap_ofs = (state == ST_WAIT_OFS) && rd_valid;
        ctl.cap_seg = (state == ST_WAIT_SEG) && rd_valid;
    end

    assign busy = (state != ST_IDLE);

    // Push counter used only by the checks below
    logic [2:0] push_cnt;
    always_ff @(posedge clk) begin
        if (rst || ctl.load) push_cnt <= '0;
        else if (ctl.push)   push_cnt <= push_cnt + 3'd1;
    end

    p_rd_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        ctl.rd_req |=> !ctl.rd_req);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_three_pushes_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> push_cnt == 3'd3);
endmodule

// File: rtl/rmie_datapath.sv
module rmie_datapath
    import rmie_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned VEC_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  ctl_t               ctl,
    input  logic [VEC_W-1:0]   vector,
    input  logic [FLAGS_W-1:0] flags_in,
    input  word_t              cs_in,
    input  logic [IP_W-1:0]    ip_in,
    input  word_t              ss_in,
    input  word_t              sp_in,
    input  word_t              rd_data,
    output logic [ADDR_W-1:0]  wr_addr,
    output word_t              wr_data,
    output logic [ADDR_W-1:0]  rd_addr,
    output word_t              new_cs,
    output logic [IP_W-1:0]    new_ip,
    output word_t              new_sp,
    output logic [FLAGS_W-1:0] new_flags
);
    localparam int unsigned SEG_SHIFT = 4;

    logic [FLAGS_W-1:0] flags_q;
    word_t              cs_q, ip_q, ss_q, sp_q, ofs_q, seg_q;
    logic [VEC_W-1:0]   vec_q;
    word_t              wr_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0; cs_q <= '0; ip_q <= '0; ss_q <= '0; sp_q <= '0;
            vec_q <= '0; ofs_q <= '0; seg_q <= '0;
        end else begin
            if (ctl.load) begin
                flags_q <= flags_in;
                cs_q    <= cs_in;
                ip_q    <= ip_in[WORD_W-1:0];
                ss_q    <= ss_in;
                sp_q    <= sp_in;
                vec_q   <= vector;
            end else if (ctl.push) begin
                sp_q <= wr_off;
            end
            if (ctl.cap_ofs) ofs_q <= rd_data;
            if (ctl.cap_seg) seg_q <= rd_data;
        end
    end

    assign wr_off  = sp_q - word_t'(2);
    assign wr_addr = ADDR_W'({ss_q, {SEG_SHIFT{1'b0}}}) + ADDR_W'(wr_off);
    assign rd_addr = ADDR_W'({vec_q, ctl.rd_seg, 1'b0});

    always_comb begin
        unique case (ctl.src)
            SRC_CS:  wr_data = cs_q;
            SRC_IP:  wr_data = ip_q;
            default: wr_data = flags_q[WORD_W-1:0];
        endcase
    end

    assign new_cs    = seg_q;
    assign new_ip    = IP_W'(ofs_q);
    assign new_sp    = sp_q;
    assign new_flags = strip_ctrl(flags_q);

    p_sp_step_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.push && $past(ctl.push) |-> wr_off == $past(wr_off) - word_t'(2));
endmodule

// File: rtl/rmode_int_entry.sv
module rmode_int_entry
    import rmie_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned VEC_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [VEC_W-1:0]   vector,
    input  logic [31:0]        flags_in,
    input  logic [15:0]        cs_in,
    input  logic [31:0]        ip_in,
    input  logic [15:0]        ss_in,
    input  logic [15:0]        sp_in,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [15:0]        wr_data,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_valid,
    input  logic [15:0]        rd_data,
    output logic               busy,
    output logic               done,
    output logic [15:0]        new_cs,
    output logic [31:0]        new_ip,
    output logic [15:0]        new_sp,
    output logic [31:0]        new_flags
);
    ctl_t ctl;

    rmie_ctrl i_ctrl (
        .clk(clk), .rst(rst), .start(start), .rd_valid(rd_valid),
        .ctl(ctl), .busy(busy), .done(done)
    );

    rmie_datapath #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_dp (
        .clk(clk), .rst(rst), .ctl(ctl), .vector(vector),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
        .ss_in(ss_in), .sp_in(sp_in), .rd_data(rd_data),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp), .new_flags(new_flags)
    );

    assign wr_en  = ctl.push;
    assign rd_req = ctl.rd_req;

    p_port_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_req));
endmodule

// File: tb/test_rmode_int_entry.sv
`timescale 1ns/1ps
module test_rmode_int_entry;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic [31:0] flags_in = '0, ip_in = '0;
    logic [15:0] cs_in = '0, ss_in = '0, sp_in = '0;
    logic        wr_en, rd_req, busy, done;
    logic [19:0] wr_addr, rd_addr;
    logic [15:0] wr_data, new_cs, new_sp;
    logic [31:0] new_ip, new_flags;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;

    int n_chk = 0, n_bad = 0;
    int nw = 0, nr = 0;
    logic [19:0] w_addr [8];
    logic [15:0] w_data [8];
    logic [19:0] r_addr [8];

    always #2 clk = ~clk;

    rmode_int_entry i_rmode_int_entry (
        .clk(clk), .rst(rst), .start(start), .vector(vector),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .new_cs(new_cs), .new_ip(new_ip),
        .new_sp(new_sp), .new_flags(new_flags)
    );

    function automatic logic [15:0] tbl_ofs(input logic [7:0] v);
        return {v, ~v} ^ 16'h5A3C;
    endfunction
    function automatic logic [15:0] tbl_seg(input logic [7:0] v);
        return {~v, v} + 16'h1234;
    endfunction
    function automatic logic [19:0] lin(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction
    function automatic logic [31:0] exp_flags(input logic [31:0] f);
        return f & ~32'h0005_0300;
    endfunction

    // Memory model: one-cycle read latency; write/read logs
    always @(posedge clk) begin
        rd_valid <= rd_req;
        rd_data  <= rd_addr[1] ? tbl_seg(rd_addr[9:2]) : tbl_ofs(rd_addr[9:2]);
        if (start && !busy) begin nw = 0; nr = 0; end
        if (!rst && wr_en) begin
            if (nw < 8) begin w_addr[nw] = wr_addr; w_data[nw] = wr_data; end
            nw++;
        end
        if (!rst && rd_req) begin
            if (nr < 8) r_addr[nr] = rd_addr;
            nr++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic run_one(input logic [7:0] v, input logic [31:0] f, input logic [15:0] c,
                           input logic [31:0] ip, input logic [15:0] s, input logic [15:0] sp,
                           input bit intrude);
        int waitc;
        @(negedge clk);
        vector = v; flags_in = f; cs_in = c; ip_in = ip; ss_in = s; sp_in = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R7 busy after start", 32'(busy), 32'd1);
        if (intrude) begin
            vector = ~v; flags_in = ~f; cs_in = ~c; ip_in = ~ip; ss_in = ~s; sp_in = ~sp;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waitc = 0;
        while (done !== 1'b1 && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        chk(done === 1'b1, "R7 done reached", 32'(done), 32'd1);
        chk(busy === 1'b0, "R7 busy low at done", 32'(busy), 32'd0);
        // R4: exactly three writes, no fault code, whatever the vector
        chk(nw == 3, "R4 write count", 32'(nw), 32'd3);
        chk(nr == 2, "R1 read count", 32'(nr), 32'd2);
        for (int k = 0; k < 3; k++) begin
            logic [15:0] off;
            logic [15:0] d;
            off = sp - 16'(2 * (k + 1));
            d = (k == 0) ? f[15:0] : (k == 1) ? c : ip[15:0];
            chk(w_addr[k] === lin(s, off), intrude ? "R8 write addr" : "R2 R3 R10 write addr",
                32'(w_addr[k]), 32'(lin(s, off)));
            chk(w_data[k] === d, intrude ? "R8 write data" : "R2 write data",
                32'(w_data[k]), 32'(d));
        end
        chk(r_addr[0] === {10'h0, v, 2'b00}, "R1 offset addr", 32'(r_addr[0]), 32'({v, 2'b00}));
        chk(r_addr[1] === {10'h0, v, 2'b10}, "R1 segment addr", 32'(r_addr[1]), 32'({v, 2'b10}));
        chk(new_ip === {16'h0, tbl_ofs(v)}, "R6 new_ip", new_ip, {16'h0, tbl_ofs(v)});
        chk(new_cs === tbl_seg(v), "R6 new_cs", 32'(new_cs), 32'(tbl_seg(v)));
        chk(new_sp === sp - 16'd6, "R3 new_sp", 32'(new_sp), 32'(sp - 16'd6));
        chk(new_flags === exp_flags(f), "R5 new_flags", new_flags, exp_flags(f));
        @(negedge clk);
        chk(done === 1'b0, "R7 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy === 1'b0 && done === 1'b0, "R9 busy/done in reset", {busy, done}, 0);
        chk(wr_en === 1'b0 && rd_req === 1'b0, "R9 ports in reset", {wr_en, rd_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R9 idle after reset", 32'(busy), 0);
        // Directed corners
        run_one(8'd13, 32'hFFFF_FFFF, 16'h1111, 32'hDEAD_BEEF, 16'h2000, 16'h0002, 1'b0); // R3 wrap
        run_one(8'd8,  32'h0005_0302, 16'h0700, 32'h0000_0100, 16'h0000, 16'h0000, 1'b0); // R3 sp=0
        run_one(8'hFF, 32'h0000_0202, 16'hF000, 32'h0001_FFF0, 16'hFFFF, 16'hFFF0, 1'b0); // R10 wrap
        run_one(8'd14, 32'h0002_4246, 16'h1234, 32'h0000_5678, 16'h3000, 16'h7C00, 1'b1); // R8
        run_one(8'd0,  32'h0000_0000, 16'h0000, 32'h0000_0000, 16'h0000, 16'h0100, 1'b0);
        // Random runs
        for (int i = 0; i < 40; i++) begin
            logic [7:0] v;
            v = (i % 5 == 0) ? 8'(10 + (i % 8)) : 8'($urandom);
            run_one(v, $urandom, 16'($urandom), $urandom, 16'($urandom), 16'($urandom),
                    (i % 7) == 3);
        end
        summary();
        $finish;
    end
endmodule